// File: doc/BRIEF.md
# DMA Channel Event Interrupt Aggregator

This block collects per-channel event pulses from an eight-channel DMA engine and turns them into a single interrupt line. Five kinds of event are tracked for each channel: whole-transfer completion, block completion, source-side transaction, destination-side transaction and error. Every kind has a sticky latch that records pulses, a mask, a masked view of the latch and a write-one-to-clear port. A small summary register shows which event kinds have any unmasked bit pending. The interrupt output is the OR of the summary, gated by a global enable bit.

Software reaches the block over a simple single-cycle register bus. Mask registers and the channel-enable register use a per-bit write-enable scheme: the upper byte of the written word picks the channels to change and the lower byte gives their new values. Software can therefore change one channel's bit without reading the register first. A channel's enable bit drops by itself when that channel reports transfer completion.

Top module: `dma_irq_agg`

## Requirements
- R1: A pulse on `evtIn[e*8+c]` sets latch bit c of event kind e at the next clock edge. The kinds are numbered 0 transfer, 1 block, 2 source transaction, 3 destination transaction, 4 error. The bit stays set until it is cleared.
- R2: A write to the clear register of kind e clears each latch bit whose data bit [c] is 1. Data bits that are 0 leave their latch bits as they are. An event pulse on the same bit in the same cycle wins, and the bit stays set.
- R3: A write to the mask register of kind e changes only the channels c with data bit [8+c] set, and each such bit takes the value of data bit [c]. A mask bit of 1 lets the event through. A read returns the eight mask bits in [7:0] and zeros above them.
- R4: The status register of kind e reads as the latch bits ANDed with the mask bits.
- R5: The summary register at 0x360 has bit e set when any status bit of kind e is set.
- R6: `irqOut` is 1 exactly when bit 0 of the global configuration register is 1 and at least one summary bit is set.
- R7: The channel-enable register at 0x3A0 uses the same per-bit write-enable scheme as the masks and is also driven out on `chanEnOut`. A transfer-completion pulse on channel c clears enable bit c. If a write tries to set that bit in the same cycle, the clear wins.
- R8: The address map places the latch registers at 0x2C0 + 8*e, status at 0x2E8 + 8*e, masks at 0x310 + 8*e and clears at 0x338 + 8*e. Clear registers and unmapped addresses read as 0.
- R9: After reset, every latch, mask, enable and configuration bit is 0 and `irqOut` is 0.
- R10: The global configuration register at 0x398 holds bit 0 exactly as written, so software can poll it back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 40 | Event pulses, index e*8+c |
| wrEn | input | 1 | Register write strobe |
| addr | input | 10 | Register byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irqOut | output | 1 | Aggregated interrupt |
| chanEnOut | output | 8 | Channel enable bits |

## Verification
Writes and event pulses take effect at the first rising edge at which they are presented. The read path is combinational. Any register result is therefore due in the cycle after its stimulus, and `irqOut` and `chanEnOut` move in that same cycle. The bench drives every stimulus on a falling edge and removes it on the next falling edge. It then sets the read address and samples one nanosecond later, so each check looks at the state that exactly one rising edge has produced. The two same-cycle collisions, an event against a clear and a transfer completion against an enable write, are driven in a single cycle and checked one cycle later.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  parameter int NCH = 8;
  parameter int NEV = 5;
  parameter int AW  = 10;
  parameter int DW  = 32;
  localparam int EVW    = $clog2(NEV);
  localparam int STRIDE = 8;
  localparam int XFER_EV = 0;
  localparam logic [AW-1:0] RAW_BASE  = AW'('h2C0);
  localparam logic [AW-1:0] STAT_BASE = AW'('h2E8);
  localparam logic [AW-1:0] MASK_BASE = AW'('h310);
  localparam logic [AW-1:0] CLR_BASE  = AW'('h338);
  localparam logic [AW-1:0] SUM_ADDR  = AW'('h360);
  localparam logic [AW-1:0] CFG_ADDR  = AW'('h398);
  localparam logic [AW-1:0] EN_ADDR   = AW'('h3A0);

  typedef enum logic [2:0] {RD_NONE, RD_RAW, RD_STAT, RD_MASK, RD_SUM, RD_CFG, RD_EN} rdKind_e;

  typedef struct packed {
    logic [NEV-1:0] clrWr;
    logic [NEV-1:0] maskWr;
    logic           cfgWr;
    logic           enWr;
    rdKind_e        rdKind;
    logic [EVW-1:0] rdEv;
  } strobe_t;

  typedef logic [NEV-1:0][NCH-1:0] evGrid_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  output strobe_t       stb
);
  always_comb begin
    stb = '0;
    stb.rdKind = RD_NONE;
    for (int e = 0; e < NEV; e++) begin
      if (addr == RAW_BASE + AW'(e * STRIDE)) begin
        stb.rdKind = RD_RAW;
        stb.rdEv   = EVW'(e);
      end
      if (addr == STAT_BASE + AW'(e * STRIDE)) begin
        stb.rdKind = RD_STAT;
        stb.rdEv   = EVW'(e);
      end
      if (addr == MASK_BASE + AW'(e * STRIDE)) begin
        stb.rdKind    = RD_MASK;
        stb.rdEv      = EVW'(e);
        stb.maskWr[e] = wrEn;
      end
      if (addr == CLR_BASE + AW'(e * STRIDE)) begin
        stb.clrWr[e] = wrEn;
      end
    end
    if (addr == SUM_ADDR) stb.rdKind = RD_SUM;
    if (addr == CFG_ADDR) begin
      stb.rdKind = RD_CFG;
      stb.cfgWr  = wrEn;
    end
    if (addr == EN_ADDR) begin
      stb.rdKind = RD_EN;
      stb.enWr   = wrEn;
    end
  end
endmodule

// File: rtl/dma_irq_dp.sv
module dma_irq_dp
  import dma_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb,
  input  logic [DW-1:0]  wrData,
  input  evGrid_t        evt,
  output logic [DW-1:0]  rdData,
  output logic           irqOut,
  output evGrid_t        rawQ,
  output evGrid_t        maskQ,
  output logic [NCH-1:0] enQ,
  output logic           cfgQ
);
  logic [NCH-1:0] wrVal, wrSel;
  evGrid_t        statV;
  logic [NEV-1:0] sumV;

  assign wrVal = wrData[NCH-1:0];
  assign wrSel = wrData[2*NCH-1:NCH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ  <= '0;
      maskQ <= '0;
    end else begin
      for (int e = 0; e < NEV; e++) begin
        rawQ[e] <= evt[e] | (rawQ[e] & ~(stb.clrWr[e] ? wrVal : '0));
        if (stb.maskWr[e]) maskQ[e] <= (maskQ[e] & ~wrSel) | (wrVal & wrSel);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      cfgQ <= 1'b0;
    end else begin
      enQ <= (stb.enWr ? ((enQ & ~wrSel) | (wrVal & wrSel)) : enQ) & ~evt[XFER_EV];
      if (stb.cfgWr) cfgQ <= wrData[0];
    end
  end

  always_comb begin
    for (int e = 0; e < NEV; e++) begin
      statV[e] = rawQ[e] & maskQ[e];
      sumV[e]  = |statV[e];
    end
  end

  assign irqOut = cfgQ & (|sumV);

  always_comb begin
    case (stb.rdKind)
      RD_RAW:  rdData = DW'(rawQ[stb.rdEv]);
      RD_STAT: rdData = DW'(statV[stb.rdEv]);
      RD_MASK: rdData = DW'(maskQ[stb.rdEv]);
      RD_SUM:  rdData = DW'(sumV);
      RD_CFG:  rdData = DW'(cfgQ);
      RD_EN:   rdData = DW'(enQ);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NEV*NCH-1:0] evtIn,
  input  logic               wrEn,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wrData,
  output logic [DW-1:0]      rdData,
  output logic               irqOut,
  output logic [NCH-1:0]     chanEnOut
);
  strobe_t        stb;
  evGrid_t        evtGrid;
  evGrid_t        rawQ;
  evGrid_t        maskQ;
  logic [NCH-1:0] enQ;
  logic           cfgQ;

  assign evtGrid   = evtIn;
  assign chanEnOut = enQ;

  dma_irq_ctrl u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  dma_irq_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .evt    (evtGrid),
    .rdData (rdData),
    .irqOut (irqOut),
    .rawQ   (rawQ),
    .maskQ  (maskQ),
    .enQ    (enQ),
    .cfgQ   (cfgQ)
  );
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk
  import dma_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NEV*NCH-1:0] evtIn,
  input logic               wrEn,
  input logic               irqOut,
  input logic [NEV*NCH-1:0] rawFlat,
  input logic [NEV*NCH-1:0] maskFlat,
  input logic [NCH-1:0]     enQ,
  input logic               cfgQ
);
  assert_evt_latches_R1: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((rawFlat & $past(evtIn)) == $past(evtIn)));

  assert_raw_falls_on_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((~rawFlat & $past(rawFlat)) != '0) |-> $past(wrEn));

  assert_mask_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> $stable(maskFlat));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (cfgQ && ((rawFlat & maskFlat) != '0)));

  assert_en_rise_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((enQ & ~$past(enQ)) != '0) |-> $past(wrEn));

  assert_en_selfclear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn[NCH-1:0] != '0) |=> ((enQ & $past(evtIn[NCH-1:0])) == '0));
endmodule

bind dma_irq_agg dma_irq_agg_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evtIn    (evtIn),
  .wrEn     (wrEn),
  .irqOut   (irqOut),
  .rawFlat  (rawQ),
  .maskFlat (maskQ),
  .enQ      (enQ),
  .cfgQ     (cfgQ)
);

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] evtIn = '0;
  logic        wrEn = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  logic [7:0]  chanEnOut;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_irq_agg u_dma_irq_agg (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .chanEnOut(chanEnOut)
  );

  function automatic logic [9:0] rawA(int e);  return 10'(32'h2C0 + 8*e); endfunction
  function automatic logic [9:0] statA(int e); return 10'(32'h2E8 + 8*e); endfunction
  function automatic logic [9:0] maskA(int e); return 10'(32'h310 + 8*e); endfunction
  function automatic logic [9:0] clrA(int e);  return 10'(32'h338 + 8*e); endfunction
  localparam logic [9:0] SUM = 10'h360, CFG = 10'h398, ENR = 10'h3A0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d, logic [39:0] ev = '0);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; evtIn = ev;
    @(negedge clk);
    wrEn = 1'b0; evtIn = '0;
  endtask

  task automatic pulse(logic [39:0] ev);
    @(negedge clk);
    evtIn = ev;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic chkRd(string req, logic [9:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic t_reset();
    chkRd("R9 raw xfer", rawA(0), 0);
    chkRd("R9 mask err", maskA(4), 0);
    chkRd("R9 sum", SUM, 0);
    chkRd("R10 cfg", CFG, 0);
    chkRd("R9 en", ENR, 0);
    chk("R9 irq", {31'b0, irqOut}, 0);
  endtask

  task automatic t_raw();
    pulse(40'd1 << (1*8+3));
    chkRd("R1 raw block", rawA(1), 32'h08);
    chkRd("R4 status masked", statA(1), 0);
    chk("R6 irq masked", {31'b0, irqOut}, 0);
  endtask

  task automatic t_mask();
    wr(maskA(1), 32'h101 << 3);
    chkRd("R3 mask unmask", maskA(1), 32'h08);
    chkRd("R4 status", statA(1), 32'h08);
    chkRd("R5 sum", SUM, 32'h02);
    chk("R6 irq gated", {31'b0, irqOut}, 0);
    wr(CFG, 32'h1);
    chkRd("R10 cfg set", CFG, 32'h1);
    chk("R6 irq on", {31'b0, irqOut}, 1);
  endtask

  task automatic t_maskWe();
    wr(maskA(1), 32'h00F7);
    chkRd("R3 no we", maskA(1), 32'h08);
    wr(maskA(1), 32'h0F0F);
    chkRd("R3 partial we", maskA(1), 32'h0F);
    wr(maskA(1), 32'hFF00);
    chkRd("R3 mask all", maskA(1), 0);
    chkRd("R5 sum clear", SUM, 0);
    chk("R6 irq off", {31'b0, irqOut}, 0);
  endtask

  task automatic t_clear();
    wr(clrA(1), 32'h0);
    chkRd("R2 zero write", rawA(1), 32'h08);
    wr(clrA(1), 32'h08);
    chkRd("R2 clear", rawA(1), 0);
    pulse(40'd1 << (4*8+4));
    wr(clrA(4), 32'h12, 40'd1 << (4*8+1));
    chkRd("R2 event wins", rawA(4), 32'h02);
  endtask

  task automatic t_chanEn();
    wr(ENR, 32'h101 << 5);
    chkRd("R7 en ch5", ENR, 32'h20);
    wr(ENR, 32'h101 << 2);
    chkRd("R7 en ch2", ENR, 32'h24);
    chk("R7 chanEnOut", {24'b0, chanEnOut}, 32'h24);
    pulse(40'd1 << 5);
    chkRd("R7 selfclear", ENR, 32'h04);
    wr(ENR, 32'h4040, 40'd1 << 6);
    chkRd("R7 xfer wins", ENR, 32'h04);
    chkRd("R1 raw xfer", rawA(0), 32'h60);
  endtask

  task automatic t_map();
    chkRd("R8 unmapped", 10'h100, 0);
    chkRd("R8 clear reads 0", clrA(4), 0);
    pulse(40'd1 << (3*8+7));
    chkRd("R8 raw dst", rawA(3), 32'h80);
    wr(maskA(4), 32'h0303);
    chkRd("R8 mask err", maskA(4), 32'h03);
    chkRd("R8 status err", statA(4), 32'h02);
    chkRd("R5 sum err", SUM, 32'h10);
    chk("R6 irq err", {31'b0, irqOut}, 1);
    wr(CFG, 32'h0);
    chkRd("R10 cfg cleared", CFG, 0);
    chk("R6 irq disabled", {31'b0, irqOut}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_raw();
    t_mask();
    t_maskWe();
    t_clear();
    t_chanEn();
    t_map();
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule